// File: doc/BRIEF.md
# Three-Level Nested Interrupt Controller

This block arbitrates interrupt requests for a small processor core. Request lines from the sources are grouped into nine vector slots, two lines per slot, and either line of a pair raises its slot. Each slot has an enable bit and a level-select bit. The level-select bit chooses between low and an elevated level. The elevated level is "highest" for the two external-interrupt slots and "high" for every other slot.

The controller registers the winning request and presents it to the processor as an interrupt request with a vector address. It holds both until the processor acknowledges. On acknowledge, the presented level becomes the level in service. A return-from-interrupt pulse restores the level that was in service before it. Only a request whose level is strictly above the level in service may be presented, so a handler can be interrupted only by something more urgent. The nesting record is a set of active-level flags. Because nesting levels only ever rise, three flags hold every reachable nesting state. The processor's own stack is outside this block.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `irq` is 0, `vector` is 00h and `cur_level` is 0.
- R2: A slot whose `slot_en` bit is 0 is never presented, even while its request lines are high.
- R3: Slot i is requesting when `src_req[2*i]` or `src_req[2*i+1]` is high, and its `slot_en` bit is 1.
- R4: `cur_level` uses the encoding 0 = none, 1 = low, 2 = high, 3 = highest. A slot with `lvl_sel` bit 0 is low. With `lvl_sel` bit 1, slots 0 and 1 are highest and slots 2 to 8 are high.
- R5: Among the eligible requesting slots, the slot with the greatest level is presented. If several slots share that level, the slot with the smallest index is presented.
- R6: The vector presented for slot i is 03h + 8h*i. Slot 0 gives 03h and slot 8 gives 43h.
- R7: A request whose level is equal to or below `cur_level` is not presented. It stays pending until `cur_level` falls below it.
- R8: `irq` rises at the clock edge after the edge that samples an eligible request. While `irq` is high and `ack` is low, `irq` and `vector` stay unchanged, even if a more urgent request arrives.
- R9: `ack` while `irq` is high makes `cur_level` equal to the presented level and drops `irq` at the same edge. Arbitration resumes at the following edge. `ack` while `irq` is low has no effect.
- R10: `reti` returns `cur_level` to the level that was in service before the last acknowledge, or to 0 if there was none. `reti` is ignored when nothing is in service, and it is ignored in a cycle where an acknowledge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 18 | Request lines; lines 2i and 2i+1 belong to slot i |
| slot_en | input | 9 | Per-slot enable |
| lvl_sel | input | 9 | Per-slot level select (0 low, 1 elevated) |
| ack | input | 1 | Processor accepts the presented interrupt |
| reti | input | 1 | Processor returns from the current handler |
| irq | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector address of the presented slot |
| cur_level | output | 2 | Level currently in service (0 none) |

## Verification
A request sampled at edge N appears on `irq` and `vector` after edge N. An `ack` or `reti` sampled at edge N moves `cur_level` after edge N. A request that becomes eligible because of that change is presented one edge later still. The bench drives every input on the falling edge. A behavioural model updates on the rising edge from the same inputs, and all three outputs are compared against it on the following falling edge. Each output is therefore judged exactly in the cycle it is due. The directed scenarios add explicit expected values at those same falling edges, including holds of several cycles for requests that must stay unpresented.

// File: rtl/nic_pkg.sv
package nic_pkg;

  // Level encoding shared by arbiter, stack and top (see R4)
  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_NONE = 2'd0;
  localparam lvl_t LVL_LOW  = 2'd1;
  localparam lvl_t LVL_HIGH = 2'd2;
  localparam lvl_t LVL_TOP  = 2'd3;

  localparam int LVL_COUNT = 3;

endpackage

// File: rtl/nic_slot_map.sv
module nic_slot_map
  import nic_pkg::*;
#(
  parameter int NUM_SLOTS     = 9,
  parameter int SRC_PER_SLOT  = 2,
  parameter int NUM_TOP_SLOTS = 2
) (
  input  logic [NUM_SLOTS*SRC_PER_SLOT-1:0] src_req,
  input  logic [NUM_SLOTS-1:0]              slot_en,
  input  logic [NUM_SLOTS-1:0]              lvl_sel,
  output logic [NUM_SLOTS-1:0]              slot_req,
  output lvl_t [NUM_SLOTS-1:0]              slot_lvl
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    // R3: any source of the pair raises the slot; R2: enable gates it
    assign slot_req[g] = slot_en[g] & (|src_req[g*SRC_PER_SLOT +: SRC_PER_SLOT]);

    // R4: elevated level depends on the slot position
    if (g < NUM_TOP_SLOTS) begin : g_top
      assign slot_lvl[g] = lvl_sel[g] ? LVL_TOP : LVL_LOW;
    end else begin : g_std
      assign slot_lvl[g] = lvl_sel[g] ? LVL_HIGH : LVL_LOW;
    end
  end

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int NUM_SLOTS = 9,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] slot_req,
  input  lvl_t [NUM_SLOTS-1:0] slot_lvl,
  input  lvl_t                 cur_level,
  output logic                 win_valid,
  output logic [IDX_W-1:0]     win_idx,
  output lvl_t                 win_lvl
);

  // Scan from the largest index down; ">=" lets a smaller index take
  // over at equal level, ">" keeps a greater level (R5). Only levels
  // strictly above the level in service compete (R7).
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = LVL_NONE;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (slot_req[i] && (slot_lvl[i] > cur_level) && (slot_lvl[i] >= win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = slot_lvl[i];
      end
    end
  end

  AST_WIN_ABOVE_SERVICE: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (win_lvl > cur_level)); // R7

  AST_WIN_IS_REQUESTING: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> slot_req[win_idx]); // R2

  AST_NO_WIN_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
    (slot_req == '0) |-> !win_valid); // R2

endmodule

// File: rtl/nic_level_stack.sv
module nic_level_stack
  import nic_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  lvl_t push_lvl,
  input  logic pop,
  output lvl_t cur_level
);

  // One flag per level; nesting is strictly increasing, so the set of
  // active levels is the whole nesting history.
  logic [LVL_COUNT-1:0] act_q, act_d;
  lvl_t                 cur_q, cur_d;

  always_comb begin
    logic cleared;
    act_d   = act_q;
    cleared = 1'b0;
    if (push) begin
      for (int l = 0; l < LVL_COUNT; l++) begin
        if (push_lvl == lvl_t'(l + 1)) act_d[l] = 1'b1;
      end
    end else if (pop) begin
      for (int l = LVL_COUNT - 1; l >= 0; l--) begin
        if (act_q[l] && !cleared) begin
          act_d[l] = 1'b0;
          cleared  = 1'b1;
        end
      end
    end
    cur_d = LVL_NONE;
    for (int l = 0; l < LVL_COUNT; l++) begin
      if (act_d[l]) cur_d = lvl_t'(l + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      cur_q <= LVL_NONE;
    end else begin
      act_q <= act_d;
      cur_q <= cur_d;
    end
  end

  assign cur_level = cur_q;

  AST_PUSH_SETS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    push |=> (cur_level == $past(push_lvl))); // R9

  AST_PUSH_STRICTLY_UP: assert property (@(posedge clk) disable iff (rst)
    push |-> (push_lvl > cur_level)); // R7

  AST_POP_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && (cur_level != LVL_NONE)) |=> (cur_level < $past(cur_level))); // R10

  AST_POP_EMPTY_STAYS: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && (cur_level == LVL_NONE)) |=> (cur_level == LVL_NONE)); // R10

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_SLOTS     = 9,
  parameter int SRC_PER_SLOT  = 2,
  parameter int NUM_TOP_SLOTS = 2,
  parameter int VEC_W         = 8,
  parameter int VEC_BASE      = 3,
  parameter int VEC_STEP      = 8,
  localparam int SRC_W        = NUM_SLOTS * SRC_PER_SLOT,
  localparam int IDX_W        = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] src_req,
  input  logic [NUM_SLOTS-1:0] slot_en,
  input  logic [NUM_SLOTS-1:0] lvl_sel,
  input  logic             ack,
  input  logic             reti,
  output logic             irq,
  output logic [VEC_W-1:0] vector,
  output logic [1:0]       cur_level
);

  logic [NUM_SLOTS-1:0] slot_req;
  lvl_t [NUM_SLOTS-1:0] slot_lvl;
  logic                 win_valid;
  logic [IDX_W-1:0]     win_idx;
  lvl_t                 win_lvl;
  lvl_t                 svc_lvl;
  logic [VEC_W-1:0]     vec_next;

  logic             irq_q;
  logic [VEC_W-1:0] vec_q;
  lvl_t             pres_q;
  logic             push, pop;

  nic_slot_map #(
    .NUM_SLOTS    (NUM_SLOTS),
    .SRC_PER_SLOT (SRC_PER_SLOT),
    .NUM_TOP_SLOTS(NUM_TOP_SLOTS)
  ) u_map (
    .src_req (src_req),
    .slot_en (slot_en),
    .lvl_sel (lvl_sel),
    .slot_req(slot_req),
    .slot_lvl(slot_lvl)
  );

  nic_arbiter #(
    .NUM_SLOTS(NUM_SLOTS)
  ) u_arb (
    .clk      (clk),
    .rst      (rst),
    .slot_req (slot_req),
    .slot_lvl (slot_lvl),
    .cur_level(svc_lvl),
    .win_valid(win_valid),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  // R9: accept only while presenting; R10: return ignored in that cycle
  assign push = irq_q & ack;
  assign pop  = reti & ~push;

  nic_level_stack u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .push_lvl (pres_q),
    .pop      (pop),
    .cur_level(svc_lvl)
  );

  // R6: evenly spaced vector addresses
  assign vec_next = VEC_W'(VEC_BASE + int'(win_idx) * VEC_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      vec_q  <= '0;
      pres_q <= LVL_NONE;
    end else if (irq_q) begin
      if (ack) irq_q <= 1'b0;     // R9
    end else if (win_valid) begin // R8: load once, then hold
      irq_q  <= 1'b1;
      vec_q  <= vec_next;
      pres_q <= win_lvl;
    end
  end

  assign irq       = irq_q;
  assign vector    = vec_q;
  assign cur_level = svc_lvl;

  AST_VECTOR_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !ack) |=> (irq_q && $stable(vec_q) && $stable(pres_q))); // R8

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (irq_q && ack) |=> !irq_q); // R9

  AST_PRESENTED_ABOVE: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (pres_q > svc_lvl)); // R7

  AST_IDLE_ACK_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (!irq_q && ack && !reti) |=> $stable(svc_lvl)); // R9

endmodule

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;

  localparam int NS = 9;

  logic          clk = 1'b0;
  logic          rst;
  logic [2*NS-1:0] src_req;
  logic [NS-1:0] slot_en;
  logic [NS-1:0] lvl_sel;
  logic          ack;
  logic          reti;
  logic          irq;
  logic [7:0]    vector;
  logic [1:0]    cur_level;

  always #10 clk = ~clk; // 50 MHz

  nest_irq_ctrl i_nest_irq_ctrl (
    .clk      (clk),
    .rst      (rst),
    .src_req  (src_req),
    .slot_en  (slot_en),
    .lvl_sel  (lvl_sel),
    .ack      (ack),
    .reti     (reti),
    .irq      (irq),
    .vector   (vector),
    .cur_level(cur_level)
  );

  int    checks = 0;
  int    errors = 0;
  string tag    = "R1";

  // ---------------- behavioural reference model ----------------
  int m_irq, m_vec, m_plvl;
  int stk[$];

  function automatic int lvl_of(int i);
    if (!lvl_sel[i]) return 1;
    return (i < 2) ? 3 : 2;
  endfunction

  function automatic int m_cur();
    return (stk.size() > 0) ? stk[stk.size()-1] : 0;
  endfunction

  always @(posedge clk) begin
    int cur;
    int found;
    if (rst) begin
      m_irq = 0; m_vec = 0; m_plvl = 0;
      stk.delete();
    end else begin
      cur = m_cur();
      if (m_irq == 1 && ack) begin
        stk.push_back(m_plvl);
        m_irq = 0;
      end else begin
        if (reti && stk.size() > 0) void'(stk.pop_back());
        if (m_irq == 0) begin
          found = 0;
          for (int l = 3; l >= 1; l--) begin
            for (int i = 0; i < NS; i++) begin
              if (found == 0 && slot_en[i] && (src_req[2*i] || src_req[2*i+1])
                  && lvl_of(i) == l && l > cur) begin
                found = 1; m_irq = 1; m_plvl = l;
                m_vec = (3 + 8*i) & 8'hFF;
              end
            end
          end
        end
      end
    end
  end

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", r, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(tag, "model irq", int'(irq), m_irq);
      chk(tag, "model cur_level", int'(cur_level), m_cur());
      chk(tag, "model vector", int'(vector), m_vec);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; step(1); reti = 1'b0;
  endtask

  task automatic quiet();
    src_req = '0; lvl_sel = '0; slot_en = '1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; ack = 1'b0; reti = 1'b0;
    src_req = '0; slot_en = '1; lvl_sel = '0;
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "vector", int'(vector), 0);
    chk("R1", "cur_level", int'(cur_level), 0);

    // R3 odd source line of slot 4, R6 vector 23h
    tag = "R3";
    src_req[9] = 1'b1; step(1);
    chk("R3", "irq", int'(irq), 1);
    chk("R6", "vector slot4", int'(vector), 8'h23);
    pulse_ack();
    chk("R9", "irq after ack", int'(irq), 0);
    chk("R9", "cur after ack", int'(cur_level), 1);
    src_req = '0;
    pulse_reti();
    chk("R10", "cur after reti", int'(cur_level), 0);

    // R2 disabled slot ignored
    tag = "R2";
    slot_en[2] = 1'b0; src_req[4] = 1'b1; step(3);
    chk("R2", "irq disabled slot", int'(irq), 0);
    slot_en[2] = 1'b1; step(1);
    chk("R2", "irq enabled slot", int'(irq), 1);
    chk("R6", "vector slot2", int'(vector), 8'h13);
    pulse_ack(); src_req = '0; pulse_reti();

    // R5 highest level wins over lower indices
    tag = "R5";
    lvl_sel[3] = 1'b1;
    src_req[10] = 1'b1; src_req[14] = 1'b1; src_req[6] = 1'b1; step(1);
    chk("R5", "vector high slot3", int'(vector), 8'h1B);
    pulse_ack();
    chk("R4", "cur high", int'(cur_level), 2);
    quiet(); pulse_reti(); step(1);

    // R5 tie at same level: smaller index
    lvl_sel[6] = 1'b1; lvl_sel[2] = 1'b1;
    src_req[12] = 1'b1; src_req[5] = 1'b1; step(1);
    chk("R5", "vector tie", int'(vector), 8'h13);
    pulse_ack(); quiet(); pulse_reti(); step(1);

    // R4 slot 1 elevated to highest
    tag = "R4";
    lvl_sel[1] = 1'b1; src_req[2] = 1'b1; step(1);
    chk("R6", "vector slot1", int'(vector), 8'h0B);
    pulse_ack();
    chk("R4", "cur highest", int'(cur_level), 3);
    quiet(); pulse_reti();
    chk("R10", "cur empty", int'(cur_level), 0);

    // R7 nesting: equal level blocked, higher accepted
    tag = "R7";
    src_req[16] = 1'b1; step(1);
    chk("R6", "vector slot8", int'(vector), 8'h43);
    pulse_ack();
    src_req[0] = 1'b1; step(3);
    chk("R7", "equal level not presented", int'(irq), 0);
    lvl_sel[5] = 1'b1; src_req[11] = 1'b1; step(1);
    chk("R7", "higher presented", int'(irq), 1);
    chk("R7", "vector slot5", int'(vector), 8'h2B);
    pulse_ack();
    chk("R7", "cur nested high", int'(cur_level), 2);
    lvl_sel[0] = 1'b1; step(2);
    chk("R7", "vector slot0", int'(vector), 8'h03);
    pulse_ack();
    chk("R7", "cur nested highest", int'(cur_level), 3);
    src_req = '0;
    pulse_reti();
    chk("R10", "pop to high", int'(cur_level), 2);
    pulse_reti();
    chk("R10", "pop to low", int'(cur_level), 1);
    pulse_reti();
    chk("R10", "pop to none", int'(cur_level), 0);
    tag = "R10";
    pulse_reti();
    chk("R10", "reti when empty", int'(cur_level), 0);
    chk("R10", "irq when empty", int'(irq), 0);
    quiet(); step(1);

    // R9 ack while idle ignored
    tag = "R9";
    pulse_ack();
    chk("R9", "idle ack cur", int'(cur_level), 0);
    chk("R9", "idle ack irq", int'(irq), 0);

    // R8 hold against a more urgent arrival
    tag = "R8";
    src_req[16] = 1'b1; step(1);
    lvl_sel[1] = 1'b1; src_req[3] = 1'b1; step(2);
    chk("R8", "irq held", int'(irq), 1);
    chk("R8", "vector held", int'(vector), 8'h43);
    pulse_ack();
    chk("R9", "cur low", int'(cur_level), 1);
    chk("R9", "irq dropped", int'(irq), 0);
    step(1);
    chk("R8", "urgent presented next", int'(vector), 8'h0B);
    // R10 reti in the same cycle as an accepted ack is ignored
    ack = 1'b1; reti = 1'b1; step(1); ack = 1'b0; reti = 1'b0;
    chk("R10", "ack wins over reti", int'(cur_level), 3);
    quiet();
    pulse_reti();
    chk("R10", "back to low", int'(cur_level), 1);
    pulse_reti();
    chk("R10", "back to none", int'(cur_level), 0);

    // Random traffic against the model
    tag = "R5";
    for (int k = 0; k < 4000; k++) begin
      src_req = 18'($urandom) & 18'($urandom) & 18'($urandom);
      slot_en = 9'($urandom) | 9'($urandom);
      if (k % 16 == 0) lvl_sel = 9'($urandom);
      ack  = irq && ($urandom_range(2) == 0);
      reti = ($urandom_range(5) == 0);
      step(1);
    end
    ack = 1'b0; reti = 1'b0; quiet();
    step(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule